// File: doc/BRIEF.md
# Store Write-Back Path

This block carries a store from the execute stage of an integer pipeline out to memory through three holding registers in a row. The issue register captures the logical address, the right-justified data and the access size of each accepted store. The translate register holds the store while a translation unit maps its logical address to a physical one. The lane register holds the physical address, the byte-lane data and the byte enables that drive the external bus write.

Stores have lower priority than operand reads. While the effective-address fetch stage asks for an operand, a held store waits in the issue register. It can wait for any number of cycles. The wait ends when no operand read is requested, or when execute offers a further store, which pushes the held one forward. A translated store that hits in the data cache is written to the cache from the translate register. A store that misses goes to the lane register as a write-through bus cycle. A failed translation drops the store and signals a fault.

Top module: `wbp_store_path`

## Requirements
- R1: After a synchronous active-high reset, all three registers are empty. `ex_wr_ready` is 1, and `xl_req`, `cache_lookup`, `cache_wr`, `fault_valid` and `bus_valid` are 0.
- R2: A store is accepted in a cycle where `ex_wr_valid` and `ex_wr_ready` are both 1. Its address, data and size are captured in the issue register at that edge.
- R3: While `opf_req` is 1 and `ex_wr_valid` is 0, a store held in the issue register does not advance. `xl_req` stays 0 when the translate register is empty.
- R4: When `ex_wr_valid` is 1 while the issue register is full, the held store advances if the translate register can take it, even with `opf_req` at 1. The new store is accepted in the same cycle.
- R5: `ex_wr_ready` is 0 exactly when the issue register is full and its store cannot advance in that cycle.
- R6: The translate register raises `xl_req` with the store's logical address on `xl_req_addr`. It holds both unchanged until a cycle in which `xl_rsp_valid` is 1.
- R7: A response with `xl_rsp_fault` at 1 raises `fault_valid` in that cycle, with the store's logical address on `fault_addr`. The store is dropped and produces no cache write and no bus write.
- R8: After a successful translation, `cache_lookup` is 1 and `cache_addr` shows the physical address. If `cache_hit` is 1, `cache_wr` is raised with lane-placed data and enables, and the store leaves without a bus write.
- R9: Lane placement is big-endian on a 32-bit bus, using the two low physical address bits. Enable bit 3 is the lane for bits 31:24. Size code 0 (byte) takes the data from bits 7:0 and places it in lane 3-a, where a is addr[1:0]. Size code 1 (word) takes bits 15:0 and places them in bits 31:16 with enables 1100 when addr[1]=0, and in bits 15:0 with enables 0011 otherwise; addr[0] is ignored. Size codes 2 and 3 (longword) pass the data through with enables 1111. Lanes that are not enabled carry zero.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_addr`, `bus_data` and `bus_be` hold their values in the next cycle.
- R11: Every accepted store leaves exactly once, by fault, by cache write or by bus write. Stores leaving by the same route keep their acceptance order, and a register loads only when it is empty or being emptied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_wr_valid | input | 1 | Execute offers a store |
| ex_wr_ready | output | 1 | Issue register can take the store |
| ex_wr_addr | input | ADDR_W | Logical store address |
| ex_wr_data | input | 32 | Right-justified store data |
| ex_wr_size | input | 2 | Size code: 0 byte, 1 word, 2 or 3 longword |
| opf_req | input | 1 | Operand read requested by the fetch stage |
| xl_req | output | 1 | Translation request |
| xl_req_addr | output | ADDR_W | Logical address to translate |
| xl_rsp_valid | input | 1 | Translation response present |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_paddr | input | ADDR_W | Translated physical address |
| fault_valid | output | 1 | One-cycle fault indication |
| fault_addr | output | ADDR_W | Logical address of the faulting store |
| cache_lookup | output | 1 | Translated store presented to the cache |
| cache_addr | output | ADDR_W | Physical address for lookup and write |
| cache_hit | input | 1 | Cache holds the addressed line |
| cache_wr | output | 1 | Cache write strobe |
| cache_data | output | 32 | Lane-placed cache write data |
| cache_be | output | 4 | Cache byte enables |
| bus_valid | output | 1 | Bus write pending |
| bus_ready | input | 1 | Bus takes the write |
| bus_addr | output | ADDR_W | Physical bus address |
| bus_data | output | 32 | Lane-placed bus data |
| bus_be | output | 4 | Bus byte enables |

## Verification
The in-module properties watch the local rules on every cycle. They cover capture at acceptance, a stalled issue register keeping its contents under a pending operand read, a translation request held steady until answered, a bus write frozen while the bus stalls, the shape of every enable mask, and the translate register never loading while still full. Only the bench scenarios can show the end-to-end effects. These are the forced advance when a second store arrives, the mapping of every size and offset onto the right lanes, the split between fault, cache and bus exits, and that every store leaves exactly once and in order along its route.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;

    typedef enum logic [1:0] {
        ACC_BYTE     = 2'd0,
        ACC_WORD     = 2'd1,
        ACC_LONG     = 2'd2,
        ACC_LONG_ALT = 2'd3
    } acc_size_e;

    // data and size travelling with a store
    typedef struct packed {
        logic [BUS_W-1:0] data;
        acc_size_e        size;
    } st_pay_t;

    // lane-placed data with byte enables
    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [LANES-1:0] be;
    } lane_t;

    // big-endian lane placement: lane 0 of the address is bits 31:24
    function automatic lane_t lane_place(acc_size_e sz, logic [1:0] lo,
                                         logic [BUS_W-1:0] d);
        lane_t r;
        r.data = '0;
        r.be   = '0;
        case (sz)
            ACC_BYTE: begin
                r.be   = 4'b1000 >> lo;
                r.data = {d[7:0], 24'h000000} >> {lo, 3'b000};
            end
            ACC_WORD: begin
                if (lo[1]) begin
                    r.be   = 4'b0011;
                    r.data = {16'h0000, d[15:0]};
                end else begin
                    r.be   = 4'b1100;
                    r.data = {d[15:0], 16'h0000};
                end
            end
            default: begin
                r.be   = '1;
                r.data = d;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wbp_issue_reg.sv
module wbp_issue_reg
    import wbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  st_pay_t           in_pay,
    input  logic              opf_req,
    input  logic              down_room,
    output logic              go,
    output logic [ADDR_W-1:0] out_addr,
    output st_pay_t           out_pay
);

    logic              vld;
    logic [ADDR_W-1:0] addr_q;
    st_pay_t           pay_q;

    // a held store yields to operand reads unless a newer store pushes it
    assign go       = vld && down_room && (!opf_req || in_valid);
    assign in_ready = !vld || go;
    assign out_addr = addr_q;
    assign out_pay  = pay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
        end else if (in_valid && in_ready) begin
            vld <= 1'b1;
        end else if (go) begin
            vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            addr_q <= in_addr;
            pay_q  <= in_pay;
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (vld && addr_q == $past(in_addr) && pay_q == $past(in_pay)));

    p_opf_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (vld && opf_req && !in_valid) |=> (vld && $stable(addr_q) && $stable(pay_q)));

    p_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (vld && !down_room) |-> !in_ready);

endmodule

// File: rtl/wbp_xlate_reg.sv
module wbp_xlate_reg
    import wbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_load,
    input  logic [ADDR_W-1:0] in_addr,
    input  st_pay_t           in_pay,
    output logic              room,
    output logic              xl_req,
    output logic [ADDR_W-1:0] xl_req_addr,
    input  logic              xl_rsp_valid,
    input  logic              xl_rsp_fault,
    input  logic [ADDR_W-1:0] xl_rsp_paddr,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              cache_lookup,
    output logic [ADDR_W-1:0] cache_addr,
    input  logic              cache_hit,
    output logic              cache_wr,
    output logic [BUS_W-1:0]  cache_data,
    output logic [LANES-1:0]  cache_be,
    input  logic              c_room,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_paddr,
    output st_pay_t           fwd_pay
);

    logic              vld;
    logic              xdone;
    logic [ADDR_W-1:0] la_q;
    logic [ADDR_W-1:0] pa_q;
    st_pay_t           pay_q;
    logic              rsp_take;
    logic              empty_now;
    lane_t             placed;

    assign xl_req      = vld && !xdone;
    assign xl_req_addr = la_q;
    assign rsp_take    = xl_req && xl_rsp_valid;

    assign fault_valid = rsp_take && xl_rsp_fault;
    assign fault_addr  = la_q;

    assign cache_lookup = vld && xdone;
    assign cache_addr   = pa_q;
    assign cache_wr     = cache_lookup && cache_hit;
    assign placed       = lane_place(pay_q.size, pa_q[1:0], pay_q.data);
    assign cache_data   = placed.data;
    assign cache_be     = placed.be;

    // a miss becomes a write-through once the lane register has space
    assign fwd_valid = cache_lookup && !cache_hit && c_room;
    assign fwd_paddr = pa_q;
    assign fwd_pay   = pay_q;

    assign empty_now = fault_valid || cache_wr || fwd_valid;
    assign room      = !vld || empty_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            xdone <= 1'b0;
        end else if (in_load) begin
            vld   <= 1'b1;
            xdone <= 1'b0;
        end else if (empty_now) begin
            vld   <= 1'b0;
            xdone <= 1'b0;
        end else if (rsp_take) begin
            xdone <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (in_load) begin
            la_q  <= in_addr;
            pay_q <= in_pay;
        end
        if (rsp_take && !xl_rsp_fault) begin
            pa_q <= xl_rsp_paddr;
        end
    end

    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (xl_req && !xl_rsp_valid) |=> (xl_req && $stable(xl_req_addr)));

    p_fault_drop_r7: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !cache_lookup);

    p_load_space_r11: assert property (@(posedge clk) disable iff (rst)
        in_load |-> room);

endmodule

// File: rtl/wbp_lane_reg.sv
module wbp_lane_reg
    import wbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_paddr,
    input  st_pay_t           in_pay,
    output logic              room,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_data,
    output logic [LANES-1:0]  bus_be
);

    logic              vld;
    logic [ADDR_W-1:0] pa_q;
    lane_t             lanes_q;

    assign room      = !vld || bus_ready;
    assign bus_valid = vld;
    assign bus_addr  = pa_q;
    assign bus_data  = lanes_q.data;
    assign bus_be    = lanes_q.be;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
        end else if (in_valid) begin
            vld <= 1'b1;
        end else if (bus_ready) begin
            vld <= 1'b0;
        end
    end

    // steering happens as the store enters this register
    always_ff @(posedge clk) begin
        if (in_valid) begin
            pa_q    <= in_paddr;
            lanes_q <= lane_place(in_pay.size, in_paddr[1:0], in_pay.data);
        end
    end

    p_bus_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                       $stable(bus_data) && $stable(bus_be)));

    p_be_shape_r9: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_be inside {4'b1000, 4'b0100, 4'b0010, 4'b0001,
                                      4'b1100, 4'b0011, 4'b1111}));

    p_idle_lanes_r9: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> ((bus_data & ~{{8{bus_be[3]}}, {8{bus_be[2]}},
                                     {8{bus_be[1]}}, {8{bus_be[0]}}}) == '0));

endmodule

// File: rtl/wbp_store_path.sv
module wbp_store_path
    import wbp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_wr_valid,
    output logic              ex_wr_ready,
    input  logic [ADDR_W-1:0] ex_wr_addr,
    input  logic [31:0]       ex_wr_data,
    input  logic [1:0]        ex_wr_size,
    input  logic              opf_req,
    output logic              xl_req,
    output logic [ADDR_W-1:0] xl_req_addr,
    input  logic              xl_rsp_valid,
    input  logic              xl_rsp_fault,
    input  logic [ADDR_W-1:0] xl_rsp_paddr,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              cache_lookup,
    output logic [ADDR_W-1:0] cache_addr,
    input  logic              cache_hit,
    output logic              cache_wr,
    output logic [31:0]       cache_data,
    output logic [3:0]        cache_be,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_data,
    output logic [3:0]        bus_be
);

    st_pay_t           ex_pay;
    logic              a_go;
    logic [ADDR_W-1:0] a_addr;
    st_pay_t           a_pay;
    logic              b_room;
    logic              b_fwd;
    logic [ADDR_W-1:0] b_paddr;
    st_pay_t           b_pay;
    logic              c_room;

    assign ex_pay.data = ex_wr_data;
    assign ex_pay.size = acc_size_e'(ex_wr_size);

    wbp_issue_reg #(.ADDR_W(ADDR_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ex_wr_valid),
        .in_ready  (ex_wr_ready),
        .in_addr   (ex_wr_addr),
        .in_pay    (ex_pay),
        .opf_req   (opf_req),
        .down_room (b_room),
        .go        (a_go),
        .out_addr  (a_addr),
        .out_pay   (a_pay)
    );

    wbp_xlate_reg #(.ADDR_W(ADDR_W)) u_xlate (
        .clk          (clk),
        .rst          (rst),
        .in_load      (a_go),
        .in_addr      (a_addr),
        .in_pay       (a_pay),
        .room         (b_room),
        .xl_req       (xl_req),
        .xl_req_addr  (xl_req_addr),
        .xl_rsp_valid (xl_rsp_valid),
        .xl_rsp_fault (xl_rsp_fault),
        .xl_rsp_paddr (xl_rsp_paddr),
        .fault_valid  (fault_valid),
        .fault_addr   (fault_addr),
        .cache_lookup (cache_lookup),
        .cache_addr   (cache_addr),
        .cache_hit    (cache_hit),
        .cache_wr     (cache_wr),
        .cache_data   (cache_data),
        .cache_be     (cache_be),
        .c_room       (c_room),
        .fwd_valid    (b_fwd),
        .fwd_paddr    (b_paddr),
        .fwd_pay      (b_pay)
    );

    wbp_lane_reg #(.ADDR_W(ADDR_W)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (b_fwd),
        .in_paddr  (b_paddr),
        .in_pay    (b_pay),
        .room      (c_room),
        .bus_valid (bus_valid),
        .bus_ready (bus_ready),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_be    (bus_be)
    );

    p_one_exit_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({fault_valid, cache_wr, b_fwd}) <= 1);

    p_force_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        (ex_wr_valid && ex_wr_ready && opf_req && xl_req && !xl_rsp_valid)
            |=> $stable(xl_req_addr));

endmodule

// File: tb/sim_wbp_store_path.sv
`timescale 1ns/1ps
module sim_wbp_store_path;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_wr_valid = 1'b0;
    logic        ex_wr_ready;
    logic [31:0] ex_wr_addr = '0;
    logic [31:0] ex_wr_data = '0;
    logic [1:0]  ex_wr_size = '0;
    logic        opf_req = 1'b0;
    logic        xl_req;
    logic [31:0] xl_req_addr;
    logic        xl_rsp_valid = 1'b0;
    logic        xl_rsp_fault = 1'b0;
    logic [31:0] xl_rsp_paddr = '0;
    logic        fault_valid;
    logic [31:0] fault_addr;
    logic        cache_lookup;
    logic [31:0] cache_addr;
    logic        cache_hit = 1'b0;
    logic        cache_wr;
    logic [31:0] cache_data;
    logic [3:0]  cache_be;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic [3:0]  bus_be;

    always #2 clk = ~clk;

    wbp_store_path #(.ADDR_W(32)) u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // accepted stores and per-route queues of indices into them
    logic [31:0] w_la [0:4095];
    logic [31:0] w_d  [0:4095];
    logic [1:0]  w_sz [0:4095];
    int n_wr = 0;
    int tq [0:4095]; int tq_h = 0; int tq_t = 0;
    int fq [0:4095]; int fq_h = 0; int fq_t = 0;
    int cq [0:4095]; int cq_h = 0; int cq_t = 0;
    int bq [0:4095]; int bq_h = 0; int bq_t = 0;

    int  xl_max = 0;
    int  xl_wait = 0;
    bit  bus_rand = 1'b0;
    bit  prev_stall = 1'b0;
    logic [31:0] hold_a, hold_d;
    logic [3:0]  hold_be;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] map_pa(input logic [31:0] la);
        return {la[31:12] ^ 20'h00A5A, la[11:0]};
    endfunction

    function automatic bit is_fault(input logic [31:0] la);
        return la[31:28] == 4'hE;
    endfunction

    function automatic logic [35:0] exp_lane(input logic [1:0] sz,
                                             input logic [31:0] pa,
                                             input logic [31:0] d);
        logic [31:0] data;
        logic [3:0]  be;
        int k;
        if (sz == 2'd0) begin
            k = 3 - int'(pa[1:0]);
            be = 4'(1 << k);
            data = (d & 32'hFF) << (8 * k);
        end else if (sz == 2'd1) begin
            k = 1 - int'(pa[1]);
            be = pa[1] ? 4'd3 : 4'd12;
            data = (d & 32'hFFFF) << (16 * k);
        end else begin
            be = 4'hF;
            data = d;
        end
        return {data, be};
    endfunction

    task automatic push(input logic [31:0] la, input logic [31:0] d,
                        input logic [1:0] sz);
        w_la[n_wr] = la; w_d[n_wr] = d; w_sz[n_wr] = sz;
        tq[tq_t] = n_wr; tq_t++;
        if (is_fault(la)) begin
            fq[fq_t] = n_wr; fq_t++;
        end else if (map_pa(la)[6]) begin
            cq[cq_t] = n_wr; cq_t++;
        end else begin
            bq[bq_t] = n_wr; bq_t++;
        end
        n_wr++;
    endtask

    // translator, cache and bus models plus exit monitors
    always @(negedge clk) begin
        if (!rst) begin
            if (xl_req) begin
                if (xl_wait > 0) begin
                    xl_rsp_valid = 1'b0;
                    xl_wait--;
                end else begin
                    xl_rsp_valid = 1'b1;
                    xl_rsp_paddr = map_pa(xl_req_addr);
                    xl_rsp_fault = is_fault(xl_req_addr);
                    if (tq_h < tq_t) begin
                        chk(xl_req_addr == w_la[tq[tq_h]], "R6 request address",
                            xl_req_addr, w_la[tq[tq_h]]);
                        tq_h++;
                    end else chk(1'b0, "R6 unexpected request", xl_req_addr, 0);
                    xl_wait = (xl_max > 0) ? $urandom_range(0, xl_max) : 0;
                end
            end else begin
                xl_rsp_valid = 1'b0;
                xl_rsp_fault = 1'b0;
            end
            cache_hit = cache_lookup && cache_addr[6];
            bus_ready = bus_valid && (!bus_rand || ($urandom_range(0, 2) != 0));
            if (prev_stall) begin
                chk(bus_valid && bus_addr == hold_a && bus_data == hold_d && bus_be == hold_be,
                    "R10 stalled bus write held", bus_data, hold_d);
            end
            #1;
            if (fault_valid) begin
                if (fq_h < fq_t) begin
                    chk(fault_addr == w_la[fq[fq_h]], "R7 fault address",
                        fault_addr, w_la[fq[fq_h]]);
                    fq_h++;
                end else chk(1'b0, "R7 unexpected fault", fault_addr, 0);
            end
            if (cache_wr) begin
                if (cq_h < cq_t) begin
                    logic [35:0] e;
                    int i;
                    i = cq[cq_h];
                    e = exp_lane(w_sz[i], map_pa(w_la[i]), w_d[i]);
                    chk(cache_addr == map_pa(w_la[i]), "R8 cache address",
                        cache_addr, map_pa(w_la[i]));
                    chk({cache_data, cache_be} == e, "R8 cache lanes",
                        {cache_data[27:0], cache_be}, {e[31:4], e[3:0]});
                    cq_h++;
                end else chk(1'b0, "R8 unexpected cache write", cache_addr, 0);
            end
            if (bus_valid && bus_ready) begin
                if (bq_h < bq_t) begin
                    logic [35:0] e;
                    int i;
                    i = bq[bq_h];
                    e = exp_lane(w_sz[i], map_pa(w_la[i]), w_d[i]);
                    chk(bus_addr == map_pa(w_la[i]), "R11 bus order/address",
                        bus_addr, map_pa(w_la[i]));
                    chk(bus_data == e[35:4], "R9 bus data lanes", bus_data, e[35:4]);
                    chk(bus_be == e[3:0], "R9 bus byte enables", {28'h0, bus_be},
                        {28'h0, e[3:0]});
                    bq_h++;
                end else chk(1'b0, "R11 unexpected bus write", bus_addr, 0);
            end
            prev_stall = bus_valid && !bus_ready;
            hold_a = bus_addr; hold_d = bus_data; hold_be = bus_be;
        end
    end

    task automatic send(input logic [31:0] la, input logic [31:0] d,
                        input logic [1:0] sz);
        ex_wr_valid = 1'b1; ex_wr_addr = la; ex_wr_data = d; ex_wr_size = sz;
        #1;
        while (!ex_wr_ready) begin
            @(negedge clk); #1;
        end
        push(la, d, sz);
        @(negedge clk);
        ex_wr_valid = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] la1, la2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(ex_wr_ready == 1'b1, "R1 ready after reset", {31'h0, ex_wr_ready}, 1);
        chk({xl_req, cache_lookup, cache_wr, fault_valid, bus_valid} == 5'b0,
            "R1 outputs idle after reset",
            {27'h0, xl_req, cache_lookup, cache_wr, fault_valid, bus_valid}, 0);
        @(negedge clk);

        // R2/R3/R5: store held behind operand reads
        opf_req = 1'b1;
        la1 = 32'h1000_0104;
        la2 = 32'h1000_0208;
        send(la1, 32'hA1B2_C3D4, 2'd2);
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(xl_req == 1'b0, "R3 store waits behind operand read", {31'h0, xl_req}, 0);
            chk(ex_wr_ready == 1'b0, "R5 ready low while blocked", {31'h0, ex_wr_ready}, 0);
            @(negedge clk);
        end
        // R4: a newer store forces the held one forward
        ex_wr_valid = 1'b1; ex_wr_addr = la2; ex_wr_data = 32'h0000_5566; ex_wr_size = 2'd1;
        #1;
        chk(ex_wr_ready == 1'b1, "R4 newer store accepted under operand read",
            {31'h0, ex_wr_ready}, 1);
        if (ex_wr_ready) push(la2, 32'h0000_5566, 2'd1);
        @(negedge clk);
        ex_wr_valid = 1'b0;
        #1;
        chk(xl_req && xl_req_addr == la1, "R4 held store forced to translation",
            xl_req_addr, la1);
        chk(ex_wr_ready == 1'b0, "R2 newer store captured and held", {31'h0, ex_wr_ready}, 0);
        @(negedge clk);
        opf_req = 1'b0;
        repeat (8) @(negedge clk);

        // R8/R9 exhaustive sweep of size, offset and hit
        xl_max = 1;
        for (int sz = 0; sz < 4; sz++)
            for (int lo = 0; lo < 4; lo++)
                for (int h = 0; h < 2; h++)
                    send(32'h2345_0000 | (sz << 10) | (lo << 8) | (h << 6) | lo,
                         32'h8899_AABB ^ (sz << 4) ^ lo, 2'(sz));
        // R7 faults mixed in
        send(32'hE000_0040, 32'h1111_1111, 2'd0);
        send(32'h3000_0001, 32'h2222_2222, 2'd0);
        send(32'hE123_0002, 32'h3333_3333, 2'd2);
        send(32'h3000_0046, 32'h4444_4444, 2'd1);
        repeat (10) @(negedge clk);

        // random sweep with bus stalls and operand reads
        bus_rand = 1'b1;
        xl_max = 2;
        for (int n = 0; n < 700; n++) begin
            opf_req = ($urandom_range(0, 2) == 0);
            send($urandom, $urandom, 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 3) == 0) begin
                opf_req = ($urandom_range(0, 1) == 0);
                @(negedge clk);
            end
        end
        opf_req = 1'b0;
        bus_rand = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            if (tq_h == tq_t && fq_h == fq_t && cq_h == cq_t && bq_h == bq_t) break;
            @(negedge clk);
        end
        // R11: every store left exactly once
        chk(tq_h == tq_t, "R11 all stores translated", tq_h, tq_t);
        chk(fq_h == fq_t, "R11 all faults reported", fq_h, fq_t);
        chk(cq_h == cq_t, "R11 all cache writes seen", cq_h, cq_t);
        chk(bq_h == bq_t, "R11 all bus writes seen", bq_h, bq_t);
        repeat (4) @(negedge clk);
        #1;
        chk({xl_req, bus_valid, ex_wr_ready} == 3'b001, "R11 path empty at end",
            {29'h0, xl_req, bus_valid, ex_wr_ready}, 1);
        finish_up();
    end

endmodule